// File: doc/BRIEF.md
# PDM Table-Lookup Decimation Filter

This block is the first rate-reduction stage for a bank of single-bit PDM microphones. For every channel it keeps the last 48 PDM samples and, each time a new byte of 8 samples arrives, produces one signed PCM word. That word is a 48-tap linear-phase low-pass filter evaluated at one eighth of the input rate, so with a 64·Fs bit stream the output runs at 8·Fs. No multiplier is used. The 48-bit history is cut into six 8-bit bins. Each bin's byte addresses a 256-entry table of precomputed partial sums, and the six table reads are added.

The taps are symmetric, so only three tables are built. They are computed at elaboration from a parameter array that holds the first half of the coefficient set. The three newer bins read the tables directly. The three older bins reverse the bits of their byte and read the tables in mirrored order. A byte set for all channels arrives with one strobe. A single table port and a single accumulator are then shared in time: channel after channel, one bin per cycle. The result appears on a PCM bus with a valid pulse and a channel number.

Top module: `pdm_lut_decim`

## Requirements
- R1: While `rst_n` is low and afterwards, `pcm_valid` stays low until six byte sets have been accepted. The sixth set and every later one produce outputs.
- R2: Each output equals the sum over taps i = 0..47 of +h[i] when history bit i is 1 and of −h[i] when it is 0. Tap 0 is bit 0 of the newest byte, bit 7 of a byte is its oldest sample, and taps 8..15 come from the previous byte, and so on.
- R3: The taps obey h[i] = h[47−i], and the parameter supplies h[0..23]. An isolated 1 bit gives the correct weight in every bin, including the three older bins that reuse the newer bins' tables through bit reversal.
- R4: Each accepted set yields exactly NCH single-cycle `pcm_valid` pulses, with `pcm_chan` counting up from 0 to NCH−1.
- R5: Each set shifts every channel's history by one byte. A channel's output depends only on that channel's own last six bytes.
- R6: The output for channel c is valid exactly 6·(c+1) clock cycles after the rising edge that samples `in_valid`.
- R7: A new set may be presented no earlier than NCH·6+1 cycles after the previous one. The design flags an earlier strobe.
- R8: A history that is all ones gives +Σh, and a history that is all zeros gives −Σh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: a new byte set is on `in_bytes` |
| in_bytes | input | NCH*8 | Byte of channel c in bits [8c+7:8c]; bit 0 is the newest sample |
| pcm_valid | output | 1 | One-cycle pulse per produced PCM word |
| pcm_chan | output | $clog2(NCH) | Channel of the current PCM word |
| pcm_data | output | OW | Signed PCM word |

## Verification
The bench goes after the history corners first. A lone 1 bit that walks from the newest bin into the oldest exposes a wrong bit-reversal or a wrong mirrored table order: such a design returns the weight of the wrong tap once the bit crosses the midpoint. All-zero and all-one histories hit the extremes of the sum. A design that mixes up the sign convention, or drops the accumulator clear between channels, misses those values. Channels carrying different constant bytes catch a history shared across channels. Exact-cycle sampling catches a wrong priming count or an off-by-one in the bin sequence, which would show up as a pulse one cycle early or late, or as an output during the first five sets.

// File: rtl/pdm_lut_pkg.sv
package pdm_lut_pkg;

   localparam int SAMPLES_PER_BYTE = 8;
   localparam int TABLE_DEPTH      = 1 << SAMPLES_PER_BYTE;

   typedef logic [SAMPLES_PER_BYTE-1:0] pdm_byte_t;

   // Mirror a byte so the oldest sample takes the newest position.
   function automatic pdm_byte_t flip_byte(pdm_byte_t b);
      pdm_byte_t r;
      for (int i = 0; i < SAMPLES_PER_BYTE; i++) r[i] = b[SAMPLES_PER_BYTE-1-i];
      return r;
   endfunction

endpackage

// File: rtl/pdm_lut_rom.sv
module pdm_lut_rom
   import pdm_lut_pkg::*;
#(
   parameter int NHB   = 3,
   parameter int CW    = 32,
   parameter int OW    = 32,
   parameter logic signed [CW-1:0] HALF_COEF [NHB*8] = '{default: '0},
   localparam int TW   = (NHB > 1) ? $clog2(NHB) : 1
) (
   input  logic [TW-1:0]          tbl,
   input  pdm_byte_t              pat,
   output logic signed [OW-1:0]   val
);

   // Partial sum of one bin: +h for a 1 bit, -h for a 0 bit.
   function automatic logic signed [OW-1:0] part_sum(int t, int p);
      logic signed [OW-1:0] s;
      logic signed [OW-1:0] c;
      s = '0;
      for (int j = 0; j < SAMPLES_PER_BYTE; j++) begin
         c = OW'(HALF_COEF[SAMPLES_PER_BYTE*t + j]);
         if (p[j]) s = s + c;
         else      s = s - c;
      end
      return s;
   endfunction

   logic signed [OW-1:0] tab [NHB][TABLE_DEPTH];

   for (genvar t = 0; t < NHB; t++) begin : g_tbl
      for (genvar p = 0; p < TABLE_DEPTH; p++) begin : g_ent
         localparam logic signed [OW-1:0] ENTRY = part_sum(t, p);
         assign tab[t][p] = ENTRY;
      end
   end

   assign val = tab[tbl][pat];

endmodule

// File: rtl/pdm_bin_history.sv
module pdm_bin_history
   import pdm_lut_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int NBIN = 6,
   localparam int CHW = $clog2(NCH),
   localparam int BW  = $clog2(NBIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [NCH*8-1:0]  din,
   input  logic [CHW-1:0]    rd_chan,
   input  logic [BW-1:0]     rd_bin,
   output pdm_byte_t         dout
);

   localparam pdm_byte_t IDLE_PATTERN = 8'h55;

   pdm_byte_t hist [NCH][NBIN];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < NBIN; k++) hist[c][k] <= IDLE_PATTERN;
         end else if (load) begin
            hist[c][0] <= din[8*c +: 8];
            for (int k = 1; k < NBIN; k++) hist[c][k] <= hist[c][k-1];
         end
      end
   end

   assign dout = hist[rd_chan][rd_bin];

   // R5: a load moves the newest byte one bin deeper
   a_r5_bin_shift: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> hist[0][1] == $past(hist[0][0]));

endmodule

// File: rtl/pdm_tdm_seq.sv
module pdm_tdm_seq #(
   parameter int NCH  = 8,
   parameter int NBIN = 6,
   localparam int CHW = $clog2(NCH),
   localparam int BW  = $clog2(NBIN)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic           active,
   output logic [CHW-1:0] chan,
   output logic [BW-1:0]  bin,
   output logic           last
);

   localparam logic [CHW-1:0] LAST_CH  = CHW'(NCH - 1);
   localparam logic [BW-1:0]  LAST_BIN = BW'(NBIN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         chan   <= '0;
         bin    <= '0;
      end else if (start) begin
         active <= 1'b1;
         chan   <= '0;
         bin    <= '0;
      end else if (active) begin
         if (bin == LAST_BIN) begin
            bin <= '0;
            if (chan == LAST_CH) active <= 1'b0;
            else                 chan   <= chan + 1'b1;
         end else begin
            bin <= bin + 1'b1;
         end
      end
   end

   assign last = active && (bin == LAST_BIN);

   // R4: channels are visited in ascending order within one set
   a_r4_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
      (active && bin == '0 && $past(active)) |-> chan == CHW'($past(chan) + 1'b1));

endmodule

// File: rtl/pdm_lut_decim.sv
module pdm_lut_decim
   import pdm_lut_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int NTAPS = 48,
   parameter int CW    = 32,
   parameter int OW    = 32,
   parameter logic signed [CW-1:0] HALF_COEF [NTAPS/2] = '{
      32'sd1024,   32'sd4096,   32'sd9216,   32'sd16384,  32'sd25600,  32'sd36864,
      32'sd50176,  32'sd65536,  32'sd82944,  32'sd102400, 32'sd123904, 32'sd147456,
      32'sd173056, 32'sd200704, 32'sd230400, 32'sd262144, 32'sd295936, 32'sd331776,
      32'sd369664, 32'sd409600, 32'sd451584, 32'sd495616, 32'sd541696, 32'sd589824},
   localparam int CHW  = $clog2(NCH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [NCH*8-1:0]      in_bytes,
   output logic                  pcm_valid,
   output logic [CHW-1:0]        pcm_chan,
   output logic signed [OW-1:0]  pcm_data
);

   localparam int NBIN = NTAPS / SAMPLES_PER_BYTE;
   localparam int NHB  = NBIN / 2;
   localparam int BW   = $clog2(NBIN);
   localparam int TW   = (NHB > 1) ? $clog2(NHB) : 1;
   localparam int PW   = $clog2(NBIN + 1);

   if (NTAPS < 16 || NTAPS % 16 != 0) begin : g_bad_taps
      $error("NTAPS must be a positive multiple of 16");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("NCH must be at least 2");
   end
   if (CW > OW) begin : g_bad_width
      $error("coefficient width exceeds output width");
   end

   logic            seq_active, seq_last;
   logic [CHW-1:0]  seq_chan;
   logic [BW-1:0]   seq_bin;
   pdm_byte_t       bin_byte, lut_pat;
   logic [TW-1:0]   lut_tbl;
   logic signed [OW-1:0] lut_val, acc, acc_next;
   logic [PW-1:0]   primed_cnt;
   logic            primed;

   pdm_tdm_seq #(.NCH(NCH), .NBIN(NBIN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(in_valid),
      .active(seq_active), .chan(seq_chan), .bin(seq_bin), .last(seq_last));

   pdm_bin_history #(.NCH(NCH), .NBIN(NBIN)) u_hist (
      .clk(clk), .rst_n(rst_n), .load(in_valid), .din(in_bytes),
      .rd_chan(seq_chan), .rd_bin(seq_bin), .dout(bin_byte));

   // Newer half reads directly, older half mirrored and bit-reversed.
   always_comb begin
      if (int'(seq_bin) < NHB) begin
         lut_tbl = TW'(seq_bin);
         lut_pat = bin_byte;
      end else begin
         lut_tbl = TW'(NBIN - 1 - int'(seq_bin));
         lut_pat = flip_byte(bin_byte);
      end
   end

   pdm_lut_rom #(.NHB(NHB), .CW(CW), .OW(OW), .HALF_COEF(HALF_COEF)) u_rom (
      .tbl(lut_tbl), .pat(lut_pat), .val(lut_val));

   assign acc_next = ((seq_bin == '0) ? '0 : acc) + lut_val;
   assign primed   = (primed_cnt == PW'(NBIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_cnt <= '0;
      else if (in_valid && !primed) primed_cnt <= primed_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         pcm_valid <= 1'b0;
         pcm_chan  <= '0;
         pcm_data  <= '0;
      end else begin
         pcm_valid <= 1'b0;
         if (seq_active) acc <= acc_next;
         if (seq_last) begin
            pcm_valid <= primed;
            pcm_chan  <= seq_chan;
            pcm_data  <= acc_next;
         end
      end
   end

   // R7: a new set must not arrive while the previous one is in flight
   a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !seq_active);
   // R6: a word is issued only after the last bin of a channel
   a_r6_after_last_bin: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid |-> $past(seq_last));
   // R4: each word is a single-cycle pulse
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid |=> !pcm_valid);
   // R1: nothing comes out before the history is filled
   a_r1_quiet_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid |-> primed_cnt == PW'(NBIN));

endmodule

// File: tb/pdm_lut_decim_bench.sv
`timescale 1ns/1ps
module pdm_lut_decim_bench;

   localparam int NCH = 8, NTAPS = 48, NBIN = 6;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, in_valid;
   logic [NCH*8-1:0] in_bytes;
   logic pcm_valid;
   logic [2:0] pcm_chan;
   logic signed [31:0] pcm_data;

   pdm_lut_decim u_pdm_lut_decim (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
      .pcm_valid(pcm_valid), .pcm_chan(pcm_chan), .pcm_data(pcm_data));

   int checks = 0, errors = 0, nsets = 0;
   longint cyc = 0;
   bit hist [NCH][NTAPS];
   int expv [NCH];

   function automatic int coef(int i);
      int k;
      k = (i < NTAPS/2) ? i : NTAPS - 1 - i;
      return (k + 1) * (k + 1) * 1024;
   endfunction

   function automatic int ref_out(int ch);
      int s;
      s = 0;
      for (int i = 0; i < NTAPS; i++) s += hist[ch][i] ? coef(i) : -coef(i);
      return s;
   endfunction

   function automatic int coef_sum();
      int s;
      s = 0;
      for (int i = 0; i < NTAPS; i++) s += coef(i);
      return s;
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R4 watchdog: actual still running, expected done");
         summary();
         $finish;
      end
   end

   task automatic push(logic [NCH*8-1:0] b, int gap, string tag);
      bit stray;
      @(negedge clk);
      in_valid = 1'b1;
      in_bytes = b;
      for (int ch = 0; ch < NCH; ch++) begin
         for (int i = NTAPS - 1; i >= 8; i--) hist[ch][i] = hist[ch][i-8];
         for (int j = 0; j < 8; j++) hist[ch][j] = b[8*ch + j];
         expv[ch] = ref_out(ch);
      end
      nsets++;
      @(negedge clk);
      in_valid = 1'b0;
      stray = 1'b0;
      for (int k = 1; k <= NCH*NBIN + gap; k++) begin
         @(negedge clk);
         if (nsets >= NBIN && k % NBIN == 0 && k / NBIN <= NCH) begin
            // R4 R6: channel k/6-1 is due on exactly this cycle
            int c;
            c = k / NBIN - 1;
            checks++;
            if (pcm_valid !== 1'b1 || pcm_chan !== 3'(c) || pcm_data !== expv[c]) begin
               errors++;
               $display("FAIL %s R4 R6 set %0d ch %0d: actual v=%0b ch=%0d data=%0d, expected v=1 ch=%0d data=%0d",
                        tag, nsets, c, pcm_valid, pcm_chan, pcm_data, c, expv[c]);
            end
         end else if (pcm_valid !== 1'b0) begin
            stray = 1'b1;
            errors++;
            $display("FAIL %s R1 R4 set %0d cycle %0d: actual pcm_valid=%0b, expected 0",
                     tag, nsets, k, pcm_valid);
         end
      end
      if (nsets < NBIN) begin
         checks++;  // R1 quiet priming set
         if (stray) $display("FAIL R1 priming set %0d: actual output seen, expected none", nsets);
      end
   endtask

   initial begin
      logic [NCH*8-1:0] b;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; in_valid = 1'b0; in_bytes = '0;
      for (int ch = 0; ch < NCH; ch++)
         for (int i = 0; i < NTAPS; i++) hist[ch][i] = (i % 2 == 0);
      repeat (3) @(negedge clk);
      checks++;
      if (pcm_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 in reset: actual pcm_valid=%0b, expected 0", pcm_valid);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (pcm_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 after reset: actual pcm_valid=%0b, expected 0", pcm_valid);
      end

      // R1 priming, then R8 all-zero history
      for (int s = 0; s < NBIN; s++) push('0, 1, "R1");
      checks++;
      if (expv[0] != -coef_sum()) begin
         errors++;
         $display("FAIL R8 model: actual %0d expected %0d", expv[0], -coef_sum());
      end
      // R8 all-one history
      for (int s = 0; s < NBIN; s++) push({NCH{8'hFF}}, 0, "R8");
      checks++;
      if (expv[3] != coef_sum()) begin
         errors++;
         $display("FAIL R8 model: actual %0d expected %0d", expv[3], coef_sum());
      end
      // R3 lone bits walking through every bin, oldest and newest sample of a byte
      for (int s = 0; s < NBIN; s++) push('0, 0, "R3");
      b = '0;
      b[7:0]   = 8'h80;
      b[15:8]  = 8'h01;
      b[23:16] = 8'h10;
      b[31:24] = 8'h08;
      push(b, 0, "R3");
      for (int s = 0; s < NBIN; s++) push('0, 2, "R3");
      // R5 independent channels with distinct constants
      for (int s = 0; s < NBIN; s++) begin
         for (int ch = 0; ch < NCH; ch++) b[8*ch +: 8] = 8'(8'h11 * ch + s);
         push(b, 0, "R5");
      end
      // R2 random streams with random spacing
      for (int s = 0; s < 80; s++) begin
         for (int ch = 0; ch < NCH; ch++) b[8*ch +: 8] = 8'($urandom);
         push(b, int'($urandom % 4), "R2");
      end
      summary();
      $finish;
   end

endmodule